// File: doc/BRIEF.md
# Flash Write-Protection Guard

This block decides whether write activity aimed at a 2 MB serial NOR flash array may go ahead. The array is divided into 32 blocks of 64 KB. A 3-bit protection code selects how much of the top of the array is shielded. A lock bit, qualified by a write-protect input pin, can freeze that code and the lock bit itself against further status writes.

A controller presents each program or erase request as a 21-bit byte address plus an operation kind. One clock later the block answers with either a grant pulse or a reject pulse. Status writes arrive on a separate strobe. They either update the protection state or, when locked, are refused with the same reject pulse. The current protection state is visible on a status output at all times.

Top module: `flash_wp_guard`

## Requirements
- R1: After reset, status_o reads 4'b0111: lock bit (bit 3) is 0 and protection code (bits 2:0) is 111. No grant or reject pulse is present.
- R2: Code 000 protects nothing. Code 001 protects block 31, code 010 blocks 30-31, code 011 blocks 28-31, code 100 blocks 24-31 and code 101 blocks 16-31. Codes 110 and 111 protect blocks 0-31. The block is address bits 20:16.
- R3: A page program (op_kind_i 2'b00) is rejected when its address lies in a protected block, and granted otherwise.
- R4: A sector erase (2'b01, 4 KB) or block erase (2'b10, 64 KB) is rejected if any byte of its range lies in a protected block, and granted otherwise.
- R5: A chip erase (2'b11) is granted only when the protection code is 000. Otherwise it is rejected.
- R6: While wp_pin_i is 1, a status write always loads the code and lock bit, whatever the lock bit holds.
- R7: While wp_pin_i is 0 and the lock bit is 0, a status write loads the code and lock bit.
- R8: While wp_pin_i is 0 and the lock bit is 1, a status write leaves status_o unchanged and produces a one-cycle reject pulse.
- R9: grant_o and reject_o are registered one-cycle pulses, due in the cycle after the strobe. Neither is raised in a cycle after no strobe.
- R10: A rejected request changes no protection state.
- R11: When an operation and a status write arrive in the same cycle, the operation is judged against the code held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin_i | input | 1 | Write-protect pin level; 0 lets the lock bit take effect |
| sts_wr_i | input | 1 | Status write strobe |
| sts_code_i | input | 3 | Protection code to write |
| sts_lock_i | input | 1 | Lock bit value to write |
| op_req_i | input | 1 | Program/erase request strobe |
| op_kind_i | input | 2 | 00 page program, 01 sector erase, 10 block erase, 11 chip erase |
| op_addr_i | input | 21 | Target byte address |
| grant_o | output | 1 | Request allowed (pulse) |
| reject_o | output | 1 | Request or status write refused (pulse) |
| status_o | output | 4 | {lock, code[2:0]} currently held |

## Verification
Every strobe's grant and reject pulses and its new status value are due exactly one clock edge after the edge that samples the strobe. The driver applies inputs on the falling edge and queues an expected item stamped with the cycle count one past the current one. The monitor samples just after each falling edge and compares only the items stamped for that cycle. Idle cycles also queue an item that expects both pulses low, so stray pulses are caught in the cycle where they would appear.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        OP_PAGE_PROG  = 2'b00,
        OP_SECT_ERASE = 2'b01,
        OP_BLK_ERASE  = 2'b10,
        OP_CHIP_ERASE = 2'b11
    } wp_op_e;

    localparam int CODE_W = 3;

    typedef struct packed {
        logic              lock;
        logic [CODE_W-1:0] code;
    } wp_status_t;

    localparam wp_status_t STATUS_RESET = '{lock: 1'b0, code: '1};

    function automatic logic code_is_clear(input logic [CODE_W-1:0] c);
        return c == '0;
    endfunction

endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
    parameter int BLK_W = 5
) (
    input  logic [wp_pkg::CODE_W-1:0] code,
    input  logic [BLK_W-1:0]          blk,
    output logic                      hit
);
    localparam logic [BLK_W:0] ONE     = (BLK_W+1)'(1);
    localparam logic [BLK_W:0] NBLK_V  = ONE << BLK_W;

    logic [BLK_W:0] span;
    logic [BLK_W:0] lower;

    always_comb begin
        span  = ONE << (code - 3'd1);
        lower = NBLK_V - span;
        if (wp_pkg::code_is_clear(code))
            hit = 1'b0;
        else if ({1'b0, code} > 4'(BLK_W))
            hit = 1'b1;
        else
            hit = ({1'b0, blk} >= lower);
    end
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
    import wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_req,
    input  logic       wp_pin,
    input  wp_status_t wr_val,
    output wp_status_t cur,
    output logic       wr_blocked
);
    logic rst_q;

    assign wr_blocked = wr_req && !wp_pin && cur.lock;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)
            cur <= STATUS_RESET;
        else if (wr_req && !wr_blocked)
            cur <= wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst && rst_q)
            p_reset_state_r1: assert (cur == STATUS_RESET)
                else $error("status not at reset value");
    end

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wp_pin && cur.lock) |=> $stable(cur));

    p_pin_high_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wp_pin) |=> (cur == $past(wr_val)));
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int BLK_SHIFT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_pin_i,
    input  logic              sts_wr_i,
    input  logic [2:0]        sts_code_i,
    input  logic              sts_lock_i,
    input  logic              op_req_i,
    input  logic [1:0]        op_kind_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    output logic              grant_o,
    output logic              reject_o,
    output logic [3:0]        status_o
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    wp_status_t     cur;
    wp_status_t     wr_val;
    logic           sts_blocked;
    logic           blk_hit;
    logic           allow;
    wp_op_e         kind;
    logic [BLK_W-1:0] blk;

    assign wr_val   = '{lock: sts_lock_i, code: sts_code_i};
    assign kind     = wp_op_e'(op_kind_i);
    assign blk      = op_addr_i[ADDR_W-1:BLK_SHIFT];
    assign status_o = cur;

    wp_status_reg u_status (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (sts_wr_i),
        .wp_pin     (wp_pin_i),
        .wr_val     (wr_val),
        .cur        (cur),
        .wr_blocked (sts_blocked)
    );

    wp_region_decode #(.BLK_W(BLK_W)) u_decode (
        .code (cur.code),
        .blk  (blk),
        .hit  (blk_hit)
    );

    // Erase ranges never straddle a block, so the target block decides all kinds.
    always_comb begin
        unique case (kind)
            OP_CHIP_ERASE: allow = code_is_clear(cur.code);
            default:       allow = !blk_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o  <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            grant_o  <= op_req_i && allow;
            reject_o <= (op_req_i && !allow) || sts_blocked;
        end
    end

    p_chip_erase_r5: assert property (@(posedge clk) disable iff (rst)
        (op_req_i && kind == OP_CHIP_ERASE && status_o[2:0] != 3'b000)
            |=> (reject_o && !grant_o));

    p_full_cover_r2: assert property (@(posedge clk) disable iff (rst)
        (op_req_i && status_o[2:1] == 2'b11) |=> !grant_o);

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!op_req_i && !sts_wr_i) |=> (!grant_o && !reject_o));

    p_grant_src_r9: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> $past(op_req_i));
endmodule

// File: tb/sim_flash_wp_guard.sv
`timescale 1ns/1ps
module sim_flash_wp_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_pin_i = 1'b1;
    logic        sts_wr_i = 1'b0;
    logic [2:0]  sts_code_i = '0;
    logic        sts_lock_i = 1'b0;
    logic        op_req_i = 1'b0;
    logic [1:0]  op_kind_i = '0;
    logic [20:0] op_addr_i = '0;
    logic        grant_o, reject_o;
    logic [3:0]  status_o;

    always #2 clk = ~clk;

    flash_wp_guard u0 (.*);

    typedef struct {
        int         due;
        logic       g;
        logic       r;
        logic [3:0] s;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    logic [2:0] m_code = 3'b111;
    logic       m_lock = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic exp_prot(input logic [2:0] c, input logic [20:0] a);
        logic [4:0] b;
        b = a[20:16];
        case (c)
            3'd0: return 1'b0;
            3'd1: return b >= 5'd31;
            3'd2: return b >= 5'd30;
            3'd3: return b >= 5'd28;
            3'd4: return b >= 5'd24;
            3'd5: return b >= 5'd16;
            default: return 1'b1;
        endcase
    endfunction

    task automatic step(input logic req, input logic [1:0] k, input logic [20:0] a,
                        input logic sw, input logic [2:0] c, input logic lk,
                        input logic pin, input string tag);
        exp_t e;
        logic ok;
        @(negedge clk);
        op_req_i = req; op_kind_i = k; op_addr_i = a;
        sts_wr_i = sw; sts_code_i = c; sts_lock_i = lk; wp_pin_i = pin;
        ok = (k == 2'b11) ? (m_code == 3'b000) : !exp_prot(m_code, a);
        e.due = cyc + 1;
        e.g = req && ok;
        e.r = (req && !ok) || (sw && !pin && m_lock);
        if (sw && !(!pin && m_lock)) begin
            m_code = c; m_lock = lk;
        end
        e.s = {m_lock, m_code};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic op(input logic [1:0] k, input logic [20:0] a, input string tag);
        step(1'b1, k, a, 1'b0, 3'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic swr(input logic [2:0] c, input logic lk, input logic pin, input string tag);
        step(1'b0, 2'b00, '0, 1'b1, c, lk, pin, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 2'b00, '0, 1'b0, 3'b0, 1'b0, 1'b1, tag);
    endtask

    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (grant_o !== e.g || reject_o !== e.r || status_o !== e.s) begin
                n_fail++;
                $display("FAIL %s: got g=%b r=%b s=%b, expected g=%b r=%b s=%b",
                         e.tag, grant_o, reject_o, status_o, e.g, e.r, e.s);
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        n_run++;
        if (status_o !== 4'b0111 || grant_o !== 1'b0 || reject_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got s=%b g=%b r=%b, expected s=0111 g=0 r=0",
                     status_o, grant_o, reject_o);
        end
        op(2'b00, 21'h000000, "R2 code111 low addr");
        op(2'b11, 21'h000000, "R5 chip erase at reset");
        swr(3'b000, 1'b0, 1'b1, "R6 clear code");
        op(2'b00, 21'h1FFFFF, "R3 code000 top");
        op(2'b11, 21'h000000, "R5 chip erase code000");
        swr(3'b001, 1'b0, 1'b1, "R6 code001");
        op(2'b00, 21'h1F0000, "R3 block31 program");
        op(2'b00, 21'h1EFFFF, "R3 block30 program");
        op(2'b01, 21'h1F0FFF, "R4 sector in block31");
        op(2'b10, 21'h1E0000, "R4 block erase block30");
        op(2'b10, 21'h1F0000, "R4 block erase block31");
        op(2'b11, 21'h000000, "R5 chip erase code001");
        for (int c = 2; c <= 5; c++) begin
            logic [20:0] lo;
            lo = 21'h200000 - (21'h010000 << (c - 1));
            swr(3'(c), 1'b0, 1'b1, "R6 set code");
            op(2'b00, lo, "R2 lower bound");
            op(2'b01, lo - 21'd1, "R2 below bound");
        end
        swr(3'b110, 1'b0, 1'b1, "R6 code110");
        op(2'b00, 21'h000000, "R2 code110 block0");
        idle("R9 idle");
        idle("R9 idle");
        swr(3'b011, 1'b1, 1'b0, "R7 pin low unlocked write");
        swr(3'b000, 1'b0, 1'b0, "R8 locked write");
        op(2'b00, 21'h1C0000, "R10 protection kept");
        op(2'b00, 21'h1BFFFF, "R8 below code011");
        swr(3'b000, 1'b1, 1'b1, "R6 pin high overrides lock");
        step(1'b1, 2'b00, 21'h000000, 1'b1, 3'b111, 1'b1, 1'b1, "R11 same cycle");
        op(2'b00, 21'h000000, "R11 after write");
        swr(3'b000, 1'b0, 1'b0, "R8 locked again");
        idle("R9 idle end");
        idle("R9 idle end");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule